// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors held in its own descriptor memory. Each descriptor takes four 32-bit words: status first, then control with the byte count, then the buffer address, then a next-address word that the engine never reads. Software fills a descriptor through a word-wide write port and hands it to the engine by setting the ownership flag in the status word. It then pulses the poll input to wake an engine that has gone to sleep. For every owned descriptor the engine reads the buffer one byte at a time from a byte source and sends each byte on a valid/ready stream. It then writes a completion status back and clears ownership.

When the engine finds a descriptor that it does not own, it suspends and stays idle until the next poll. The end-of-ring flag sends the walk back to the programmed base index. Without that flag the index wraps from the last slot to slot zero. A level-sensitive run input gates the engine. Dropping it lets the frame in flight finish, and then the engine stops. A 3-bit state output shows the current process state.

Top module: `txring_dma`

## Requirements
- R1: After reset the state output reads 0, the stream is idle and every status word reads zero.
- R2: The state output uses only these codes: 0 stopped, 1 fetching a descriptor, 3 transferring bytes, 4 writing back, 6 suspended.
- R3: An owned descriptor with length N>0 produces exactly N stream bytes in ascending address order. Byte k is the source byte at buffer address + k. The address and data hold while valid is high and ready is low.
- R4: Control bit 29 (first segment) raises tx_first on byte 0 only. Control bit 30 (last segment) raises tx_last on the final byte only. Control bit 27 (setup frame) raises tx_setup on every byte of that descriptor.
- R5: A successful descriptor gets its status word written to 0x00000000, which clears ownership (bit 31).
- R6: A descriptor with length field (bits LEN_W-1:0) zero sends no bytes, and its status word becomes 0x00008000 (error summary, bit 15).
- R7: Finding status bit 31 clear sends the engine to suspended with no bytes sent. It stays suspended until a poll pulse, which makes it re-read that same descriptor.
- R8: After a descriptor with control bit 25 (end of ring), the next descriptor is the one at the base index. Otherwise the next index is the current index plus one, and it wraps from DESC_NUM-1 to 0.
- R9: With run low, a descriptor in progress completes and is written back, and then the state becomes stopped. A suspended engine with run low also goes to stopped.
- R10: A base write while stopped sets both the base index and the current descriptor index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start/stop gate for the engine |
| poll | input | 1 | Poll-demand pulse, wakes a suspended engine |
| base_we | input | 1 | Base index write strobe (taken when stopped) |
| base_idx | input | IDX_W | New ring base descriptor index |
| sw_we | input | 1 | Descriptor memory word write strobe |
| sw_addr | input | IDX_W+2 | Word address: descriptor index, word within descriptor |
| sw_wdata | input | 32 | Word write data |
| sw_rdata | output | 32 | Word read data at sw_addr |
| src_addr | output | 32 | Byte address presented to the byte source |
| src_data | input | 8 | Byte returned by the source for src_addr |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a first-segment descriptor |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_setup | output | 1 | Byte belongs to a setup-frame descriptor |
| tx_state | output | 3 | Process state code |

## Verification
The assertions check the legal state codes, source address stability under backpressure, the move to write-back after a last byte, quiet waiting while suspended, wake-up on poll, and the stop after write-back once run is low, all on every cycle. Only the bench scenarios can show byte values and counts, the status words written back, the ring order across an end-of-ring flag and a natural wrap, and that a descriptor after a stop stays untouched. Those depend on descriptor contents that the checker does not see.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int DESC_NUM = 8,
  parameter int LEN_W    = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          poll,
  input  logic                          base_we,
  input  logic [$clog2(DESC_NUM)-1:0]   base_idx,
  input  logic                          sw_we,
  input  logic [$clog2(DESC_NUM)+1:0]   sw_addr,
  input  logic [31:0]                   sw_wdata,
  output logic [31:0]                   sw_rdata,
  output logic [31:0]                   src_addr,
  input  logic [7:0]                    src_data,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [7:0]                    tx_data,
  output logic                          tx_first,
  output logic                          tx_last,
  output logic                          tx_setup,
  output logic [2:0]                    tx_state
);
  localparam int IDX_W = $clog2(DESC_NUM);
  localparam int AW    = IDX_W + 2;
  localparam int WORDS = 4 * DESC_NUM;

  localparam logic [2:0] S_STOP  = 3'd0;
  localparam logic [2:0] S_FETCH = 3'd1;
  localparam logic [2:0] S_XFER  = 3'd3;
  localparam logic [2:0] S_CLOSE = 3'd4;
  localparam logic [2:0] S_SUSP  = 3'd6;

  logic [31:0]      mem [WORDS];
  logic [2:0]       state;
  logic [IDX_W-1:0] base, cur;
  logic [LEN_W-1:0] cnt, len;
  logic [31:0]      bufa;
  logic             fs, ls, setup, eor, err;

  wire [AW-1:0]    a_st  = {cur, 2'b00};
  wire [AW-1:0]    a_ctl = {cur, 2'b01};
  wire [AW-1:0]    a_buf = {cur, 2'b10};
  wire             owned = mem[a_st][31];
  wire [LEN_W-1:0] dlen  = mem[a_ctl][LEN_W-1:0];
  wire             final_byte = (cnt == len - 1'b1);
  wire [IDX_W-1:0] nxt = eor ? base :
                         (cur == IDX_W'(DESC_NUM - 1)) ? '0 : cur + 1'b1;

  assign sw_rdata = mem[sw_addr];
  assign tx_state = state;
  assign tx_valid = (state == S_XFER);
  assign src_addr = bufa + 32'(cnt);
  assign tx_data  = src_data;
  assign tx_first = tx_valid && fs && (cnt == '0);
  assign tx_last  = tx_valid && ls && final_byte;
  assign tx_setup = tx_valid && setup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (sw_we) mem[sw_addr] <= sw_wdata;
      if (state == S_CLOSE) mem[a_st] <= {16'h0, err, 15'h0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_STOP;
      base  <= '0;
      cur   <= '0;
      cnt   <= '0;
      len   <= '0;
      bufa  <= '0;
      fs    <= 1'b0;
      ls    <= 1'b0;
      setup <= 1'b0;
      eor   <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (state)
        S_STOP: begin
          if (base_we) begin
            base <= base_idx;
            cur  <= base_idx;
          end else if (run) begin
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!run) begin
            state <= S_STOP;
          end else if (!owned) begin
            state <= S_SUSP;
          end else begin
            len   <= dlen;
            bufa  <= mem[a_buf];
            fs    <= mem[a_ctl][29];
            ls    <= mem[a_ctl][30];
            setup <= mem[a_ctl][27];
            eor   <= mem[a_ctl][25];
            cnt   <= '0;
            err   <= (dlen == '0);
            state <= (dlen == '0) ? S_CLOSE : S_XFER;
          end
        end
        S_SUSP: begin
          if (!run)      state <= S_STOP;
          else if (poll) state <= S_FETCH;
        end
        S_XFER: begin
          if (tx_ready) begin
            if (final_byte) state <= S_CLOSE;
            else            cnt   <= cnt + 1'b1;
          end
        end
        S_CLOSE: begin
          cur   <= nxt;
          state <= run ? S_FETCH : S_STOP;
        end
        default: state <= S_STOP;
      endcase
    end
  end
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        poll,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_last,
  input logic [2:0]  tx_state,
  input logic [31:0] src_addr
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd6}); // R2

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(src_addr)); // R3

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> tx_state == 3'd4); // R4

  AST_SUSP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state == 3'd6 && run && !poll |=> tx_state == 3'd6); // R7

  AST_POLL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state == 3'd6 && run && poll |=> tx_state == 3'd1); // R7

  AST_STOP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state == 3'd4 && !run |=> tx_state == 3'd0); // R9
endmodule

bind txring_dma txring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .poll(poll),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
  .tx_state(tx_state), .src_addr(src_addr)
);

// File: tb/txring_dma_tb.sv
module txring_dma_tb;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] LSG = 32'h4000_0000;
  localparam logic [31:0] FSG = 32'h2000_0000;
  localparam logic [31:0] SET = 32'h0800_0000;
  localparam logic [31:0] EOR = 32'h0200_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, run = 1'b0, poll = 1'b0, base_we = 1'b0, sw_we = 1'b0;
  logic [2:0]  base_idx = '0;
  logic [4:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0, sw_rdata, src_addr;
  logic [7:0]  src_data, tx_data;
  logic        tx_valid, tx_ready, tx_first, tx_last, tx_setup;
  logic [2:0]  tx_state;
  logic [7:0]  ready_ctr = '0;
  logic        slow = 1'b0;

  int n_chk = 0, n_err = 0, tot = 0;
  bit done = 0;
  logic [7:0] cap_d [64];
  logic       cap_f [64], cap_l [64], cap_s [64];

  assign src_data = src_addr[7:0] ^ src_addr[15:8];
  assign tx_ready = !slow || (ready_ctr % 3 != 0);
  always @(posedge clk) ready_ctr <= ready_ctr + 1'b1;

  txring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .base_we(base_we),
    .base_idx(base_idx), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .src_addr(src_addr), .src_data(src_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .tx_setup(tx_setup), .tx_state(tx_state)
  );

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready && tot < 64) begin
      cap_d[tot] = tx_data; cap_f[tot] = tx_first;
      cap_l[tot] = tx_last; cap_s[tot] = tx_setup;
      tot++;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_addr = 5'(a); sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    sw_addr = 5'(a); #1 v = sw_rdata;
  endtask

  task automatic put(input int d, input logic [31:0] st, input logic [31:0] ctl, input logic [31:0] bp);
    wr(d * 4, st); wr(d * 4 + 1, ctl); wr(d * 4 + 2, bp);
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_st(input logic [2:0] s, input string tag);
    int t = 0;
    while (tx_state !== s && t < 500) begin @(negedge clk); t++; end
    chk(tag, 32'(tx_state), 32'(s));
  endtask

  task automatic chk_bytes(input int mark, input int n, input logic [31:0] ba,
                           input bit fsf, input bit lsf, input bit stf, input string tag);
    chk({tag, " count"}, 32'(tot - mark), 32'(n));
    for (int k = 0; k < n; k++) begin
      logic [31:0] a = ba + 32'(k);
      chk({tag, " data"}, 32'(cap_d[mark + k]), 32'(a[7:0] ^ a[15:8]));
      chk({tag, " first"}, 32'(cap_f[mark + k]), 32'(fsf && k == 0));
      chk({tag, " last"}, 32'(cap_l[mark + k]), 32'(lsf && k == n - 1));
      chk({tag, " setup"}, 32'(cap_s[mark + k]), 32'(stf));
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 state", 32'(tx_state), 32'd0);
    chk("R1 valid", 32'(tx_valid), 32'd0);
    rd(0, v);  chk("R1 status0", v, 32'h0);
    rd(28, v); chk("R1 status7", v, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int mark = tot;
    slow = 1'b1;
    put(0, OWN, LSG | FSG | 32'd5, 32'h100);
    @(negedge clk); run = 1'b1;
    wait_st(3'd6, "R7 suspend after frame");
    chk_bytes(mark, 5, 32'h100, 1, 1, 0, "R3 R4 single");
    rd(0, v); chk("R5 status0 written back", v, 32'h0);
  endtask

  task automatic t_suspend_poll();
    logic [31:0] v;
    int mark;
    put(1, OWN, LSG | FSG | 32'd3, 32'h200);
    mark = tot;
    repeat (10) @(negedge clk);
    chk("R7 stays suspended", 32'(tx_state), 32'd6);
    chk("R7 no bytes without poll", 32'(tot - mark), 32'd0);
    pulse_poll();
    wait_st(3'd6, "R7 after poll");
    chk_bytes(mark, 3, 32'h200, 1, 1, 0, "R7 R3 polled");
    rd(4, v); chk("R5 status1", v, 32'h0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int mark;
    put(2, OWN, LSG | FSG, 32'h280);
    mark = tot;
    pulse_poll();
    wait_st(3'd6, "R6 wait");
    chk("R6 no bytes", 32'(tot - mark), 32'd0);
    rd(8, v); chk("R6 error status", v, 32'h0000_8000);
  endtask

  task automatic t_setup();
    int mark;
    put(3, OWN, SET | 32'd2, 32'h2C0);
    mark = tot;
    pulse_poll();
    wait_st(3'd6, "R4 wait");
    chk_bytes(mark, 2, 32'h2C0, 0, 0, 1, "R4 setup no seg flags");
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int mark;
    slow = 1'b0;
    put(4, OWN, EOR | LSG | FSG | 32'd1, 32'h400);
    put(5, OWN, LSG | FSG | 32'd1, 32'h500);
    put(0, OWN, LSG | FSG | 32'd1, 32'h010);
    mark = tot;
    pulse_poll();
    wait_st(3'd6, "R8 wait");
    chk("R8 count", 32'(tot - mark), 32'd2);
    chk("R8 eor byte", 32'(cap_d[mark]), 32'h04);
    chk("R8 base byte", 32'(cap_d[mark + 1]), 32'h10);
    rd(20, v); chk("R8 skipped desc5 untouched", v, OWN);
    wr(20, 32'h0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int mark;
    put(1, OWN, LSG | FSG | 32'd12, 32'h600);
    put(2, OWN, LSG | FSG | 32'd1, 32'h700);
    mark = tot;
    pulse_poll();
    wait_st(3'd3, "R9 transfer");
    @(negedge clk); run = 1'b0;
    wait_st(3'd0, "R9 stopped");
    chk_bytes(mark, 12, 32'h600, 1, 1, 0, "R9 frame completes");
    rd(4, v); chk("R9 status1 written back", v, 32'h0);
    rd(8, v); chk("R9 next desc untouched", v, OWN);
  endtask

  task automatic t_base();
    int mark;
    @(negedge clk); base_we = 1'b1; base_idx = 3'd6;
    @(negedge clk); base_we = 1'b0;
    put(6, OWN, LSG | FSG | 32'd1, 32'h060);
    put(7, OWN, LSG | FSG | 32'd1, 32'h070);
    put(0, OWN, LSG | FSG | 32'd1, 32'h080);
    mark = tot;
    @(negedge clk); run = 1'b1;
    wait_st(3'd6, "R10 wait");
    chk("R10 count", 32'(tot - mark), 32'd3);
    chk("R10 starts at base", 32'(cap_d[mark]), 32'h60);
    chk("R8 slot7", 32'(cap_d[mark + 1]), 32'h70);
    chk("R8 wraps to slot0", 32'(cap_d[mark + 2]), 32'h80);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk("R9 suspended to stopped", 32'(tx_state), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_suspend_poll();
    t_zero();
    t_setup();
    t_wrap();
    t_stop();
    t_base();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule